// File: doc/BRIEF.md
# Interrupt presentation controller

This unit sits beside one processor and decides which external interrupt, if any, is offered to it. Source controllers send presentation requests carrying a source number, a priority and an owner tag. The unit compares each request against the processor's current priority and against whatever it already holds. It then keeps the request or hands it back, and drives a single interrupt line to the processor.

Software works the unit through a small register port. It can take the pending interrupt, look at the state without changing it, move the current priority, set the priority of a software inter-processor interrupt (IPI), and signal end of service. The unit sends three kinds of single-cycle notification back toward the sources. A reject returns a source to its owner. An end-of-service notice names the source that has been serviced. A resend request asks every source to offer again what it is still holding.

The presentation register is 32 bits wide. Bits 31:24 hold the current processor priority and bits 23:0 hold the pending source number, where zero means nothing is pending. A lower priority number is more favoured, and 0xFF is the least favoured value.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the presentation register reads 0, the IPI priority reads 0xFF, the interrupt line is low and the internal pending priority is 0xFF. Because of that last value, a take issued right after reset leaves 0xFF000000 in the register.
- R2: A request is handed back with a reject pulse that carries its own source and owner when its priority is not strictly below the current priority (bits 31:24).
- R3: A request is also handed back when a source is already pending whose pending priority is less than or equal to the request's priority. Equal priority therefore keeps the older source.
- R4: A request that is kept replaces any pending source. It latches its source number, owner and priority, and drives the interrupt line high. The replaced source gets a reject pulse to its owner, but only if it has an owner; the IPI has none.
- R5: Op 0 (take) returns the full register on rd_data in the handshake cycle. From the next cycle the interrupt line is low, bits 31:24 hold the old pending priority, bits 23:0 are 0 and the pending priority is 0xFF.
- R6: Op 2 (set priority, value in reg_wdata[7:0]) always stores the new current priority. If the new value is below the old one and a source is pending whose priority is not below the new value, that source is cleared, the line falls and the source is rejected to its owner.
- R7: A set-priority write that does not lower the priority, when nothing is pending, runs the resend sequence. A resend pulse is emitted, and the IPI is presented first if the IPI priority is below the current priority.
- R8: Op 3 (set IPI priority, value in reg_wdata[7:0]) stores the value, which is read back on rd_ipi. When the value is below the current priority and no pending source has a priority less than or equal to it, source 2 is presented at that priority with no owner, and any owned pending source is rejected.
- R9: Op 4 (end of service) loads reg_wdata[31:24] into the current priority and pulses eoi_valid with reg_wdata[23:0] on eoi_src. If nothing is pending, it then runs the resend sequence.
- R10: Op 1 (poll) changes no state, no output line and no notification.
- R11: reg_ready is always high and every register op completes in its handshake cycle. req_ready is low while reg_valid is high, and a request offered in that cycle is ignored. All notifications and the interrupt line change one clock after the causing handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Presentation request offered |
| req_ready | output | 1 | Request taken this cycle |
| req_src | input | SRC_W | Requesting source number |
| req_prio | input | PRIO_W | Request priority |
| req_owner | input | OWN_W | Tag of the sending source controller |
| reg_valid | input | 1 | Register op offered |
| reg_ready | output | 1 | Register op taken |
| reg_op | input | 3 | 0 take, 1 poll, 2 set priority, 3 set IPI priority, 4 end of service |
| reg_wdata | input | SRC_W+PRIO_W | Write value |
| rd_data | output | SRC_W+PRIO_W | Presentation register {priority, source} |
| rd_ipi | output | PRIO_W | IPI priority |
| irq | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | SRC_W | Rejected source |
| rej_owner | output | OWN_W | Owner of the rejected source |
| eoi_valid | output | 1 | End-of-service pulse |
| eoi_src | output | SRC_W | Serviced source |
| resend_valid | output | 1 | Resend request to all sources |

## Verification
The bench builds the unit with its default widths: 24 source bits, 8 priority bits and a 4-bit owner tag. With these widths the full 32-bit end-of-service value maps exactly onto the register, and the source and owner tags can be checked on every reject. Owner values up to 6 let the test tell which of two competing sources is handed back. Full 8-bit priorities reach both the 0x00 and 0xFF extremes, which gives the equal-priority ties and the "not lowered" case of the set-priority write.

// File: rtl/intr_present_unit.sv
module intr_present_unit #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int OWN_W   = 4,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  input  logic [OWN_W-1:0]        req_owner,
  input  logic                    reg_valid,
  output logic                    reg_ready,
  input  logic [2:0]              reg_op,
  input  logic [SRC_W+PRIO_W-1:0] reg_wdata,
  output logic [SRC_W+PRIO_W-1:0] rd_data,
  output logic [PRIO_W-1:0]       rd_ipi,
  output logic                    irq,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic [OWN_W-1:0]        rej_owner,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_valid
);
  localparam int XW = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);
  localparam logic [2:0] OP_TAKE = 3'd0, OP_POLL = 3'd1, OP_PRIO = 3'd2,
                         OP_IPI = 3'd3, OP_EOS = 3'd4;

  logic [PRIO_W-1:0] cur_p, pend_p, ipi_p;
  logic [SRC_W-1:0]  pend_s;
  logic [OWN_W-1:0]  own;
  logic              own_v;

  logic [PRIO_W-1:0] n_cur_p, n_pend_p, n_ipi_p, chk_p;
  logic [SRC_W-1:0]  n_pend_s, n_rej_s, n_eoi_s;
  logic [OWN_W-1:0]  n_own, n_rej_o;
  logic              n_own_v, n_irq, n_rej, n_eoi, n_rs, do_rs, do_ipi;
  logic [PRIO_W-1:0] wp;
  logic              busy;

  assign reg_ready = 1'b1;
  assign req_ready = ~reg_valid;
  assign rd_data   = {cur_p, pend_s};
  assign rd_ipi    = ipi_p;
  assign wp        = reg_wdata[PRIO_W-1:0];
  assign busy      = pend_s != '0;

  always_comb begin
    n_cur_p  = cur_p;
    n_pend_p = pend_p;
    n_ipi_p  = ipi_p;
    n_pend_s = pend_s;
    n_own    = own;
    n_own_v  = own_v;
    n_irq    = irq;
    n_rej    = 1'b0;
    n_rej_s  = pend_s;
    n_rej_o  = own;
    n_eoi    = 1'b0;
    n_eoi_s  = '0;
    n_rs     = 1'b0;
    do_rs    = 1'b0;
    do_ipi   = 1'b0;
    chk_p    = ipi_p;
    if (reg_valid) begin
      case (reg_op)
        OP_TAKE: begin
          n_irq    = 1'b0;
          n_cur_p  = pend_p;
          n_pend_s = '0;
          n_pend_p = LEAST;
          n_own_v  = 1'b0;
        end
        OP_PRIO: begin
          n_cur_p = wp;
          if (wp < cur_p) begin
            if (busy && wp <= pend_p) begin
              n_pend_s = '0;
              n_pend_p = LEAST;
              n_irq    = 1'b0;
              n_rej    = own_v;
              n_own_v  = 1'b0;
            end
          end else if (!busy) begin
            do_rs = 1'b1;
          end
        end
        OP_IPI: begin
          n_ipi_p = wp;
          if (wp < cur_p) begin
            do_ipi = 1'b1;
            chk_p  = wp;
          end
        end
        OP_EOS: begin
          n_cur_p = reg_wdata[XW-1:SRC_W];
          n_eoi   = 1'b1;
          n_eoi_s = reg_wdata[SRC_W-1:0];
          if (!busy) do_rs = 1'b1;
        end
        default: ;
      endcase
    end else if (req_valid) begin
      if (req_prio >= cur_p || (busy && pend_p <= req_prio)) begin
        n_rej   = 1'b1;
        n_rej_s = req_src;
        n_rej_o = req_owner;
      end else begin
        n_rej    = busy && own_v;
        n_pend_s = req_src;
        n_pend_p = req_prio;
        n_own    = req_owner;
        n_own_v  = 1'b1;
        n_irq    = 1'b1;
      end
    end
    if (do_rs) begin
      n_rs = 1'b1;
      if (ipi_p < n_cur_p) begin
        do_ipi = 1'b1;
        chk_p  = ipi_p;
      end
    end
    if (do_ipi && !(busy && pend_p <= chk_p)) begin
      n_rej    = busy && own_v;
      n_pend_s = IPI_NUM;
      n_pend_p = chk_p;
      n_own_v  = 1'b0;
      n_irq    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_p        <= '0;
      pend_s       <= '0;
      pend_p       <= LEAST;
      ipi_p        <= LEAST;
      own          <= '0;
      own_v        <= 1'b0;
      irq          <= 1'b0;
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      rej_owner    <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_valid <= 1'b0;
    end else begin
      cur_p        <= n_cur_p;
      pend_s       <= n_pend_s;
      pend_p       <= n_pend_p;
      ipi_p        <= n_ipi_p;
      own          <= n_own;
      own_v        <= n_own_v;
      irq          <= n_irq;
      rej_valid    <= n_rej;
      rej_src      <= n_rej_s;
      rej_owner    <= n_rej_o;
      eoi_valid    <= n_eoi;
      eoi_src      <= n_eoi_s;
      resend_valid <= n_rs;
    end
  end
endmodule

// File: rtl/intr_present_chk.sv
module intr_present_chk #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [SRC_W-1:0]        req_src,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    reg_valid,
  input logic [2:0]              reg_op,
  input logic [SRC_W+PRIO_W-1:0] reg_wdata,
  input logic [SRC_W+PRIO_W-1:0] rd_data,
  input logic                    irq,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src
);
  localparam int XW = SRC_W + PRIO_W;

  // R2
  low_prio_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_prio >= rd_data[XW-1:SRC_W]
    |=> rej_valid && rej_src == $past(req_src));

  // R4
  pending_drives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SRC_W-1:0] != '0 |-> irq);

  // R5
  take_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_op == 3'd0 |=> !irq && rd_data[SRC_W-1:0] == '0);

  // R9
  eos_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_op == 3'd4 |=> eoi_valid && eoi_src == $past(reg_wdata[SRC_W-1:0]));

  // R10
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_op == 3'd1 |=> $stable(rd_data) && $stable(irq) && !rej_valid && !eoi_valid);

  // R11
  reg_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> !req_ready);
endmodule

bind intr_present_unit intr_present_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_prio(req_prio), .reg_valid(reg_valid), .reg_op(reg_op),
  .reg_wdata(reg_wdata), .rd_data(rd_data), .irq(irq), .rej_valid(rej_valid),
  .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src));

// File: tb/test_intr_present_unit.sv
module test_intr_present_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, reg_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic [3:0]  req_owner = '0;
  logic [2:0]  reg_op = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_ready, reg_ready, irq, rej_valid, eoi_valid, resend_valid;
  logic [31:0] rd_data;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_src, eoi_src;
  logic [3:0]  rej_owner;
  int checks = 0, errors = 0;
  bit done = 0;

  intr_present_unit i_intr_present_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_prio(req_prio), .req_owner(req_owner),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .rd_ipi(rd_ipi), .irq(irq),
    .rej_valid(rej_valid), .rej_src(rej_src), .rej_owner(rej_owner),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid));

  always #10 clk = ~clk;

  typedef struct packed {
    logic        is_reg;
    logic [2:0]  op;
    logic [31:0] wd;
    logic [3:0]  own;
    logic [31:0] x_reg;
    logic        x_irq;
    logic        x_rej;
    logic [23:0] x_rsrc;
    logic [3:0]  x_rown;
    logic        x_rs;
    logic        x_eo;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd2, 32'h000000FF, 4'd0, 32'hFF000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b1, 1'b0}, // R7
    '{1'b0, 3'd0, 32'h05000010, 4'd1, 32'hFF000010, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R4
    '{1'b0, 3'd0, 32'h07000011, 4'd2, 32'hFF000010, 1'b1, 1'b1, 24'h11, 4'd2, 1'b0, 1'b0}, // R3
    '{1'b0, 3'd0, 32'h03000012, 4'd3, 32'hFF000012, 1'b1, 1'b1, 24'h10, 4'd1, 1'b0, 1'b0}, // R4
    '{1'b0, 3'd0, 32'h03000013, 4'd1, 32'hFF000012, 1'b1, 1'b1, 24'h13, 4'd1, 1'b0, 1'b0}, // R3 tie
    '{1'b1, 3'd0, 32'h0,        4'd0, 32'h03000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R5
    '{1'b0, 3'd0, 32'h02000020, 4'd2, 32'h03000020, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R4
    '{1'b0, 3'd0, 32'h03000021, 4'd2, 32'h03000020, 1'b1, 1'b1, 24'h21, 4'd2, 1'b0, 1'b0}, // R2
    '{1'b1, 3'd2, 32'h00000002, 4'd0, 32'h02000000, 1'b0, 1'b1, 24'h20, 4'd2, 1'b0, 1'b0}, // R6
    '{1'b1, 3'd3, 32'h00000001, 4'd0, 32'h02000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R8
    '{1'b0, 3'd0, 32'h00000030, 4'd4, 32'h02000030, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R4 ownerless
    '{1'b1, 3'd0, 32'h0,        4'd0, 32'h00000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R5
    '{1'b1, 3'd4, 32'hFF000030, 4'd0, 32'hFF000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b1, 1'b1}, // R9
    '{1'b1, 3'd3, 32'h000000FF, 4'd0, 32'hFF000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R8
    '{1'b1, 3'd1, 32'h0,        4'd0, 32'hFF000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R10
    '{1'b1, 3'd2, 32'h000000FF, 4'd0, 32'hFF000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R7
    '{1'b0, 3'd0, 32'h00000040, 4'd5, 32'hFF000040, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R4
    '{1'b1, 3'd3, 32'h00000000, 4'd0, 32'hFF000040, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R8
    '{1'b1, 3'd0, 32'h0,        4'd0, 32'h00000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R5
    '{1'b1, 3'd4, 32'h05000040, 4'd0, 32'h05000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b1, 1'b1}, // R9
    '{1'b1, 3'd3, 32'h000000FF, 4'd0, 32'h05000002, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R8
    '{1'b1, 3'd0, 32'h0,        4'd0, 32'h00000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R5
    '{1'b1, 3'd2, 32'h00000080, 4'd0, 32'h80000000, 1'b0, 1'b0, 24'h0,  4'd0, 1'b1, 1'b0}, // R7
    '{1'b0, 3'd0, 32'h40000050, 4'd6, 32'h80000050, 1'b1, 1'b0, 24'h0,  4'd0, 1'b0, 1'b0}, // R4
    '{1'b1, 3'd3, 32'h00000010, 4'd0, 32'h80000002, 1'b1, 1'b1, 24'h50, 4'd6, 1'b0, 1'b0}  // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    if (v.is_reg) begin
      reg_valid = 1'b1; reg_op = v.op; reg_wdata = v.wd;
    end else begin
      req_valid = 1'b1; req_src = v.wd[23:0]; req_prio = v.wd[31:24]; req_owner = v.own;
    end
    @(posedge clk);
    #2;
    reg_valid = 1'b0; req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    vec_t v;
    logic [31:0] taken;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'h0, "R1 reg", rd_data, 32'h0);
    chk(rd_ipi == 8'hFF, "R1 ipi", {24'h0, rd_ipi}, 32'hFF);
    chk(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    chk(reg_ready == 1'b1, "R11 reg_ready", {31'h0, reg_ready}, 32'h1);
    // R5 and R1: take right after reset exposes pending priority 0xFF
    v = '0; v.is_reg = 1'b1; v.op = 3'd0;
    @(negedge clk);
    reg_valid = 1'b1; reg_op = 3'd0;
    #1 taken = rd_data;
    @(posedge clk); #2 reg_valid = 1'b0;
    chk(taken == 32'h0, "R5 take returns", taken, 32'h0);
    chk(rd_data == 32'hFF000000, "R1 pending prio", rd_data, 32'hFF000000);
    // reset again to start the table from a clean state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      issue(v);
      chk(rd_data == v.x_reg, $sformatf("R4/R5/R6/R8 vec %0d reg", i), rd_data, v.x_reg);
      chk(irq == v.x_irq, $sformatf("R4 vec %0d irq", i), {31'h0, irq}, {31'h0, v.x_irq});
      chk(rej_valid == v.x_rej, $sformatf("R2/R3 vec %0d reject", i), {31'h0, rej_valid}, {31'h0, v.x_rej});
      if (v.x_rej) begin
        chk(rej_src == v.x_rsrc, $sformatf("R4 vec %0d rej_src", i), {8'h0, rej_src}, {8'h0, v.x_rsrc});
        chk(rej_owner == v.x_rown, $sformatf("R4 vec %0d rej_owner", i), {28'h0, rej_owner}, {28'h0, v.x_rown});
      end
      chk(resend_valid == v.x_rs, $sformatf("R7 vec %0d resend", i), {31'h0, resend_valid}, {31'h0, v.x_rs});
      chk(eoi_valid == v.x_eo, $sformatf("R9 vec %0d eoi", i), {31'h0, eoi_valid}, {31'h0, v.x_eo});
      if (v.x_eo)
        chk(eoi_src == v.wd[23:0], $sformatf("R9 vec %0d eoi_src", i), {8'h0, eoi_src}, {8'h0, v.wd[23:0]});
    end
    chk(rd_ipi == 8'h10, "R8 rd_ipi", {24'h0, rd_ipi}, 32'h10);
    // R11: request offered during a register op is ignored
    @(negedge clk);
    reg_valid = 1'b1; reg_op = 3'd1;
    req_valid = 1'b1; req_src = 24'h99; req_prio = 8'h00; req_owner = 4'd1;
    #1 chk(req_ready == 1'b0, "R11 req_ready", {31'h0, req_ready}, 32'h0);
    @(posedge clk); #2 reg_valid = 1'b0; req_valid = 1'b0;
    chk(rd_data == 32'h80000002, "R11 ignored req", rd_data, 32'h80000002);
    chk(rej_valid == 1'b0, "R10 poll no reject", {31'h0, rej_valid}, 32'h0);
    // R11: notifications last one cycle
    @(posedge clk); #2;
    chk(resend_valid == 1'b0 && eoi_valid == 1'b0 && rej_valid == 1'b0, "R11 pulse idle",
        {29'h0, resend_valid, eoi_valid, rej_valid}, 32'h0);
    finish_run();
  end
endmodule